// File: doc/BRIEF.md
# Edge Change-Detect Interrupt Controller

This block watches a static digital input port of 32 lines, grouped into four banks of eight. Each line can be armed for rising transitions, falling transitions, or both. Two global polarity switches in the control register gate the rising and falling paths as a whole. An armed transition on any line sets a sticky edge flag. If a further armed transition arrives while that flag is still set, an overflow flag is set as well. Software clears the two flags separately, through a write-one clear register.

The interrupt request is a masked combination of the two flags, gated by a master enable. Software reads and writes every register through a simple byte-wide bus. A write takes effect at the clock edge where the write strobe is high. Read data is a combinational function of the address. The live, synchronized level of each bank can also be read back.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset, the control register and all per-line rising and falling enable registers read 0x00. The status register at 0x02 reads 0x00 and `irq` is low.
- R2: Reading address 0x40 + 0x10·n (n = 0..3) returns the levels of `line_in[8n+7:8n]`, with bit k holding line 8n+k. A change on `line_in` shows up on this read after two rising clock edges.
- R3: The rising-enable register of bank n is at 0x42 + 0x10·n and the falling-enable register is at 0x43 + 0x10·n. Bit k of each arms line 8n+k. Both are read/write.
- R4: A rising transition on a line sets status bit 0 when both its rising-enable bit and control bit 3 are set. A falling transition sets status bit 0 when both its falling-enable bit and control bit 4 are set. A transition on a line that is not armed for that polarity has no effect. The flag is visible after the third rising clock edge that follows the input change.
- R5: Status bit 0 stays set until a write to address 0x01 with bit 3 set. A write to 0x01 with only bit 2 set leaves it unchanged.
- R6: An armed transition detected while status bit 0 is already set, and not being cleared in the same cycle, sets status bit 1 (overflow). Writing 0x01 with bit 2 set clears the overflow flag, and writing 0x01 with bit 3 set clears the edge flag. Each clear leaves the other flag unchanged, and a write of 0x0C clears both.
- R7: The control register at 0x03 holds five bits: bit 0 edge interrupt enable, bit 1 overflow interrupt enable, bit 2 master enable, bit 3 rising-edge switch, bit 4 falling-edge switch. Bits 7..5 read as zero.
- R8: `irq` = master AND ((edge flag AND edge interrupt enable) OR (overflow flag AND overflow interrupt enable)). Status bit 2 always equals `irq`.
- R9: Writing 0x00 to the control register drops `irq` from the next cycle on, while the edge and overflow flags keep their values.
- R10: The clear register and every unmapped address read 0x00. Writes to the status register, the live-level addresses and unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 32 | Asynchronous input lines, bank n on bits 8n+7..8n |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
Register writes land at the rising edge that samples the strobe, and read data follows the address combinationally. The bench therefore drives every input on the falling edge and reads one time step later, still within the low half of the clock. A line change reaches the live-level read after two rising edges and sets the status flag after three. One directed case samples both sides of each boundary. The sweeps wait four edges after every line change, so they never read a flag before it is due. `irq` depends only on registered flags and control bits, so its checks follow one edge after the write to the control register.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

  localparam logic [7:0] OFF_CLR  = 8'h01;
  localparam logic [7:0] OFF_STAT = 8'h02;
  localparam logic [7:0] OFF_CTRL = 8'h03;
  localparam logic [7:0] OFF_LIVE = 8'h40;
  localparam logic [7:0] OFF_RISE = 8'h42;
  localparam logic [7:0] OFF_FALL = 8'h43;
  localparam int unsigned BANK_STRIDE = 16;

  localparam int CLR_OVF_BIT  = 2;
  localparam int CLR_EDGE_BIT = 3;

  // bit 0 is edge_ie, bit 4 is fall_on
  typedef struct packed {
    logic fall_on;
    logic rise_on;
    logic master;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

  function automatic logic [7:0] bank_addr(logic [7:0] base, int unsigned n);
    return base + 8'(n * BANK_STRIDE);
  endfunction

  function automatic logic irq_of(logic master, logic edge_ie, logic ovf_ie,
                                  logic edge_f, logic ovf_f);
    return master & ((edge_f & edge_ie) | (ovf_f & ovf_ie));
  endfunction

endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  for (genvar i = 0; i < W; i++) begin : g_line
    logic s1, s2, pv;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        pv <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        pv <= s2;
      end
    end
    assign cur[i]  = s2;
    assign prev[i] = pv;
  end

endmodule

// File: rtl/chg_irq_detect.sv
module chg_irq_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic         rise_on,
  input  logic         fall_on,
  output logic         evt
);

  function automatic logic [W-1:0] armed_rise(logic [W-1:0] c, logic [W-1:0] p,
                                              logic [W-1:0] en, logic on);
    return c & ~p & en & {W{on}};
  endfunction

  function automatic logic [W-1:0] armed_fall(logic [W-1:0] c, logic [W-1:0] p,
                                              logic [W-1:0] en, logic on);
    return ~c & p & en & {W{on}};
  endfunction

  logic [W-1:0] hit_vec;

  always_comb begin
    hit_vec = armed_rise(cur, prev, rise_en, rise_on)
            | armed_fall(cur, prev, fall_en, fall_on);
    evt = |hit_vec;
  end

endmodule

// File: rtl/chg_irq_status.sv
module chg_irq_status
  import chg_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_edge,
  input  logic clr_ovf,
  input  logic master,
  input  logic edge_ie,
  input  logic ovf_ie,
  output logic edge_q,
  output logic ovf_q,
  output logic irq
);

  logic edge_d, ovf_d, ovf_set;

  always_comb begin
    ovf_set = evt & edge_q & ~clr_edge;
    edge_d  = evt | (edge_q & ~clr_edge);
    ovf_d   = ovf_set | (ovf_q & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      edge_q <= edge_d;
      ovf_q  <= ovf_d;
    end
  end

  assign irq = irq_of(master, edge_ie, ovf_ie, edge_q, ovf_q);

endmodule

// File: rtl/chg_irq_regs.sv
module chg_irq_regs
  import chg_irq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NBANK*DATA_W-1:0] live,
  input  logic                    edge_f,
  input  logic                    ovf_f,
  input  logic                    irq,
  output logic [DATA_W-1:0]       rdata,
  output ctrl_t                   ctrl,
  output logic [NBANK*DATA_W-1:0] rise_en,
  output logic [NBANK*DATA_W-1:0] fall_en,
  output logic                    clr_edge,
  output logic                    clr_ovf
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic [NBANK-1:0][DATA_W-1:0] rise_q, fall_q;
  logic [NBANK-1:0]             hit_live, hit_rise, hit_fall;
  logic                         hit_clr, hit_stat, hit_ctrl;
  ctrl_t                        ctrl_q;

  assign hit_clr  = (addr == ADDR_W'(OFF_CLR));
  assign hit_stat = (addr == ADDR_W'(OFF_STAT));
  assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));

  for (genvar n = 0; n < NBANK; n++) begin : g_bank
    assign hit_live[n] = (addr == ADDR_W'(bank_addr(OFF_LIVE, n)));
    assign hit_rise[n] = (addr == ADDR_W'(bank_addr(OFF_RISE, n)));
    assign hit_fall[n] = (addr == ADDR_W'(bank_addr(OFF_FALL, n)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q[n] <= '0;
        fall_q[n] <= '0;
      end else if (wr) begin
        if (hit_rise[n]) rise_q[n] <= wdata;
        if (hit_fall[n]) fall_q[n] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (wr && hit_ctrl)   ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  assign clr_edge = wr & hit_clr & wdata[CLR_EDGE_BIT];
  assign clr_ovf  = wr & hit_clr & wdata[CLR_OVF_BIT];

  always_comb begin
    rdata = '0;
    if (hit_stat) rdata = {{(DATA_W-3){1'b0}}, irq, ovf_f, edge_f};
    if (hit_ctrl) rdata = DATA_W'(ctrl_q);
    for (int n = 0; n < NBANK; n++) begin
      if (hit_live[n]) rdata = live[n*DATA_W +: DATA_W];
      if (hit_rise[n]) rdata = rise_q[n];
      if (hit_fall[n]) rdata = fall_q[n];
    end
  end

  assign ctrl    = ctrl_q;
  assign rise_en = rise_q;
  assign fall_en = fall_q;

endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*DATA_W-1:0] line_in,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    irq
);

  localparam int LINES = NBANK * DATA_W;

  logic [LINES-1:0] cur, prev, rise_en, fall_en;
  ctrl_t            ctrl_q;
  logic             det_evt, edge_q, ovf_q, irq_w, clr_edge, clr_ovf;

  chg_irq_sync #(.W(LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .cur  (cur),
    .prev (prev)
  );

  chg_irq_detect #(.W(LINES)) u_detect (
    .cur    (cur),
    .prev   (prev),
    .rise_en(rise_en),
    .fall_en(fall_en),
    .rise_on(ctrl_q.rise_on),
    .fall_on(ctrl_q.fall_on),
    .evt    (det_evt)
  );

  chg_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (det_evt),
    .clr_edge(clr_edge),
    .clr_ovf (clr_ovf),
    .master  (ctrl_q.master),
    .edge_ie (ctrl_q.edge_ie),
    .ovf_ie  (ctrl_q.ovf_ie),
    .edge_q  (edge_q),
    .ovf_q   (ovf_q),
    .irq     (irq_w)
  );

  chg_irq_regs #(.NBANK(NBANK), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .live    (cur),
    .edge_f  (edge_q),
    .ovf_f   (ovf_q),
    .irq     (irq_w),
    .rdata   (bus_rdata),
    .ctrl    (ctrl_q),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .clr_edge(clr_edge),
    .clr_ovf (clr_ovf)
  );

  assign irq = irq_w;

endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk
  import chg_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt,
  input logic              edge_q,
  input logic              ovf_q,
  input logic              clr_edge,
  input logic              clr_ovf,
  input ctrl_t             ctrl,
  input logic              irq,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  AST_EVT_SETS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> edge_q); // R4

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && !clr_edge) |=> edge_q); // R5

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !evt) |=> !edge_q); // R5

  AST_PENDING_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && edge_q && !clr_edge) |=> ovf_q); // R6

  AST_OVF_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(edge_q)); // R6

  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(evt && edge_q && !clr_edge)) |=> !ovf_q); // R6

  AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.master |-> !irq); // R8

  AST_CTRL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata == '0) |=> !irq); // R9

endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (det_evt),
  .edge_q   (edge_q),
  .ovf_q    (ovf_q),
  .clr_edge (clr_edge),
  .clr_ovf  (clr_ovf),
  .ctrl     (ctrl_q),
  .irq      (irq),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/chg_irq_ctrl_tb.sv
module chg_irq_ctrl_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  chg_irq_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (lines),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_P * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] ra;
    int j;
    int bnk;
    int bt;
    logic e_f, o_f, exp_irq;

    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(8'h02, d); chk("R1", "status", d, 8'h00);
    rd(8'h03, d); chk("R1", "ctrl", d, 8'h00);
    for (int n = 0; n < 4; n++) begin
      rd(8'h42 + 8'(16*n), d); chk("R1", "rise en", d, 8'h00);
      rd(8'h43 + 8'(16*n), d); chk("R1", "fall en", d, 8'h00);
    end
    chk("R1", "irq", irq, 1'b0);

    // R7 control width
    wr(8'h03, 8'hFF);
    rd(8'h03, d); chk("R7", "ctrl readback", d, 8'h1F);
    wr(8'h03, 8'h00);

    // R3 enable registers read back
    for (int n = 0; n < 4; n++) begin
      wr(8'h42 + 8'(16*n), 8'hA5 ^ 8'(n));
      wr(8'h43 + 8'(16*n), 8'h3C + 8'(n));
    end
    for (int n = 0; n < 4; n++) begin
      rd(8'h42 + 8'(16*n), d); chk("R3", "rise readback", d, 8'hA5 ^ 8'(n));
      rd(8'h43 + 8'(16*n), d); chk("R3", "fall readback", d, 8'h3C + 8'(n));
      wr(8'h42 + 8'(16*n), 8'h00);
      wr(8'h43 + 8'(16*n), 8'h00);
    end

    // R10 unmapped, clear register and read-only writes
    rd(8'h00, d); chk("R10", "addr 00", d, 8'h00);
    rd(8'h01, d); chk("R10", "clear reg read", d, 8'h00);
    rd(8'h41, d); chk("R10", "addr 41", d, 8'h00);
    rd(8'hFF, d); chk("R10", "addr FF", d, 8'h00);
    wr(8'h40, 8'hFF); wr(8'h02, 8'hFF); wr(8'h44, 8'hFF);
    rd(8'h40, d); chk("R10", "live after write", d, 8'h00);
    rd(8'h02, d); chk("R10", "status after write", d, 8'h00);
    rd(8'h44, d); chk("R10", "unmapped after write", d, 8'h00);
    rd(8'h03, d); chk("R10", "ctrl untouched", d, 8'h00);

    // R2 live levels
    lines = 32'hDEAD_BE5A;
    tick(2);
    for (int n = 0; n < 4; n++) begin
      rd(8'h40 + 8'(16*n), d); chk("R2", "live bank", d, lines[n*8 +: 8]);
    end
    lines = '0;
    tick(4);

    // R4 / R2 latency boundary on line 0
    wr(8'h03, 8'h18);
    wr(8'h42, 8'h01);
    wr(8'h01, 8'h0C);
    lines[0] = 1'b1;
    tick(1);
    rd(8'h40, d); chk("R2", "live after 1 edge", d, 8'h00);
    tick(1);
    rd(8'h40, d); chk("R2", "live after 2 edges", d, 8'h01);
    rd(8'h02, d); chk("R4", "status after 2 edges", d, 8'h00);
    tick(1);
    rd(8'h02, d); chk("R4", "status after 3 edges", d, 8'h01);
    wr(8'h01, 8'h0C);
    wr(8'h42, 8'h00);
    lines = '0;
    tick(4);
    wr(8'h01, 8'h0C);

    // R4 sweep over every line and polarity
    for (int i = 0; i < 32; i++) begin
      for (int p = 0; p < 2; p++) begin
        j   = (i + 1) % 32;
        bnk = i / 8;
        bt  = i % 8;
        ra  = 8'h42 + 8'(16*bnk) + 8'(p);
        lines = '0;
        if (p == 1) begin
          lines[i] = 1'b1;
          lines[j] = 1'b1;
        end
        tick(4);
        wr(8'h01, 8'h0C);
        wr(ra, 8'(1 << bt));
        lines[j] = (p == 0);
        tick(4);
        rd(8'h02, d); chk("R4", "unarmed neighbour", d, 8'h00);
        lines[i] = (p == 0);
        tick(4);
        rd(8'h02, d); chk("R4", "armed line", d, 8'h01);
        wr(8'h01, 8'h0C);
        lines[i] = (p == 1);
        tick(4);
        rd(8'h02, d); chk("R4", "opposite polarity", d, 8'h00);
        wr(ra, 8'h00);
      end
    end

    // R4 global polarity switch off
    lines = 32'h0000_0020;
    tick(4);
    wr(8'h43, 8'h20);
    wr(8'h03, 8'h08);
    wr(8'h01, 8'h0C);
    lines = '0;
    tick(4);
    rd(8'h02, d); chk("R4", "fall switch off", d, 8'h00);
    wr(8'h43, 8'h00);

    // R5 / R6 sticky flags and independent clears
    wr(8'h03, 8'h18);
    wr(8'h42, 8'h01);
    wr(8'h43, 8'h01);
    lines = '0;
    tick(4);
    wr(8'h01, 8'h0C);
    lines[0] = 1'b1; tick(4);
    rd(8'h02, d); chk("R6", "first edge", d, 8'h01);
    lines[0] = 1'b0; tick(4);
    rd(8'h02, d); chk("R6", "second edge overflows", d, 8'h03);
    wr(8'h01, 8'h04);
    rd(8'h02, d); chk("R6", "clear overflow only", d, 8'h01);
    tick(10);
    rd(8'h02, d); chk("R5", "edge sticky", d, 8'h01);
    lines[0] = 1'b1; tick(4);
    rd(8'h02, d); chk("R6", "overflow again", d, 8'h03);
    wr(8'h01, 8'h08);
    rd(8'h02, d); chk("R6", "clear edge only", d, 8'h02);
    wr(8'h01, 8'h04);
    rd(8'h02, d); chk("R6", "overflow cleared", d, 8'h00);
    lines[0] = 1'b0; tick(4);
    lines[0] = 1'b1; tick(4);
    rd(8'h02, d); chk("R6", "both set", d, 8'h03);
    wr(8'h01, 8'h0C);
    rd(8'h02, d); chk("R5", "clear both", d, 8'h00);

    // R8 interrupt combination sweep: edge only, both, overflow only
    for (int s = 0; s < 3; s++) begin
      wr(8'h03, 8'h18);
      wr(8'h01, 8'h0C);
      lines[0] = ~lines[0]; tick(4);
      if (s >= 1) begin
        lines[0] = ~lines[0]; tick(4);
      end
      if (s == 2) wr(8'h01, 8'h08);
      e_f = (s <= 1);
      o_f = (s >= 1);
      for (int c = 0; c < 8; c++) begin
        wr(8'h03, 8'h18 | 8'(c));
        exp_irq = c[2] & ((c[0] & e_f) | (c[1] & o_f));
        chk("R8", "irq output", irq, exp_irq);
        rd(8'h02, d);
        chk("R8", "status word", d, {5'b0, exp_irq, o_f, e_f});
      end
    end

    // R9 control written to zero
    wr(8'h01, 8'h0C);
    lines[0] = ~lines[0]; tick(4);
    lines[0] = ~lines[0]; tick(4);
    wr(8'h03, 8'h1F);
    chk("R9", "irq before", irq, 1'b1);
    wr(8'h03, 8'h00);
    chk("R9", "irq after zero", irq, 1'b0);
    rd(8'h02, d); chk("R9", "flags kept", d, 8'h03);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule